// File: doc/BRIEF.md
# Scrambled scan register with decoy and post-reset lock

This block is a scan register whose shift path is deliberately scrambled. Each storage stage has a two-way multiplexer: with `scan_en` low it captures functional data from the surrounding logic, and with `scan_en` high it loads a value from a shift network. That network keeps a plain chain of flip-flops, with optional inverters between stages. It adds feed-forward XOR taps into the last stage and a matching XOR correction on the serial output. Seen from the serial pins the register still behaves as a pure delay line. Reading `scan_out` bit by bit does not give the stored contents unless the tap and inverter placement is known. The XOR gates and inverters sit only on the scan path, so the functional capture path is one multiplexer, as in a plain scan cell.

A decoy flip-flop sits at the head of the chain, between `scan_in` and the first real stage. It drives no functional output. In normal mode it loads either a fixed constant or a copy of one stage's functional input, chosen by a parameter. A lock flip-flop is set by reset and forces `scan_out` to 0. It opens on the first normal-mode capture, or after enough consecutive shifts to flush every bit present at reset. An attacker therefore cannot reset the part and read the reset image to locate the inverters.

The total serial latency is `STAGES + 1` cycles: the real stages plus the decoy. Stage count, tap mask, inverter mask and the decoy variant are parameters. Illegal settings are rejected at elaboration.

Top module: `obf_scan_chain`

## Requirements
- R1: With the lock open and `scan_en` held high, the bit on `scan_in` before a clock edge appears on `scan_out` after exactly `STAGES + 1` further edges (4 with the default `STAGES = 3`), whatever the register held before.
- R2: With `scan_en` low, every bit of `func_q` takes the matching bit of `func_d` at the clock edge.
- R3: In the default configuration, after capturing `func_d = {a2,a1,a0}` (bit 2 is the last stage), the next shifts show `scan_out` = a2 XOR a1 at once, then a1 after one shift, then a0 after two shifts.
- R4: In the default configuration, one shift moves stage 0 into stage 1 unchanged and loads stage 2 with the old stage 1 XOR old stage 0. Stage 0 takes the decoy value. The result is visible on `func_q`.
- R5: The decoy loads its normal-mode value at a capture edge. In constant mode (the default, constant 1) that value is the constant. In mirror mode it is `func_d[DECOY_SRC]`. The decoy bit leaves `scan_out` after `STAGES` shifts following the capture.
- R6: After reset, `scan_out` is 0 for the first `STAGES + 1` shifts. This holds even where the reset image would read as 1. Bits shifted in during that window are kept and emerge per R1.
- R7: A normal-mode capture opens the lock, so `scan_out` shows the captured image on the very next cycle.
- R8: Reset clears every stage to 0 and closes the lock again, whatever happened before.
- R9: A configuration with `STAGES = 5`, taps from stages 0 and 2 and inverters in front of stages 1 and 2 still meets R1 (latency 6). Its output correction constant is 1, so its reset image would read as 1 without the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1 selects the shift network, 0 selects functional capture |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Serial scan data out, 0 while the lock is set |
| func_d | input | STAGES | Functional data captured in normal mode |
| func_q | output | STAGES | Stored stage contents driven to the functional logic |

## Verification
The hardest case to reach from the ports is the lock doing real work. In the default configuration the all-zero reset image already scans out as zeros, so a missing lock would go unnoticed. The bench therefore runs a second instance whose output correction constant is 1. That instance reads 1 from a freshly reset register unless the lock hides it. Both instances are then driven through partial and full flush windows, captures and repeated resets. The scrambled mapping is checked through `func_q` one shift after a capture, and through the order in which captured bits and the decoy bit emerge.

// File: rtl/obf_scan_pkg.sv
package obf_scan_pkg;

   typedef enum logic [0:0] {
      DECOY_CONST  = 1'b0,
      DECOY_MIRROR = 1'b1
   } decoy_src_e;

   // Constant XOR on the serial output that cancels the inverters seen by
   // both the plain path and the tapped correction terms.
   function automatic logic out_fix(input int unsigned k,
                                    input logic [31:0] taps,
                                    input logic [31:0] inv);
      logic p;
      p = 1'b0;
      for (int unsigned i = 0; i + 1 < k; i++) p ^= inv[5'(i)];
      for (int unsigned j = 0; j + 2 < k; j++)
         if (taps[5'(j)]) p ^= inv[5'(j + 1)];
      return p;
   endfunction

endpackage

// File: rtl/obf_scan_cell.sv
module obf_scan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_scan,
   input  logic d_func,
   input  logic d_scan,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= sel_scan ? d_scan : d_func;
   end
endmodule

// File: rtl/obf_scan_decoy.sv
module obf_scan_decoy import obf_scan_pkg::*; #(
   parameter decoy_src_e MODE      = DECOY_CONST,
   parameter logic       CONST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scan_en,
   input  logic scan_d,
   input  logic mirror_d,
   output logic q
);
   logic func_val;
   assign func_val = (MODE == DECOY_MIRROR) ? mirror_d : CONST_VAL;

   obf_scan_cell u_cell (
      .clk(clk), .rst_n(rst_n), .sel_scan(scan_en),
      .d_func(func_val), .d_scan(scan_d), .q(q)
   );

   generate
      if (MODE == DECOY_CONST) begin : g_const_chk
         // R5: a capture loads the fixed constant
         a_r5_decoy_const: assert property (@(posedge clk) disable iff (!rst_n)
            !scan_en |=> q == CONST_VAL);
      end else begin : g_mirror_chk
         // R5: a capture copies the mirrored functional input
         a_r5_decoy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
            !scan_en |=> q == $past(mirror_d));
      end
   endgenerate
endmodule

// File: rtl/obf_scan_guard.sv
module obf_scan_guard #(
   parameter int unsigned SHIFTS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scan_en,
   output logic locked
);
   localparam int unsigned CW   = (SHIFTS > 1) ? $clog2(SHIFTS) : 1;
   localparam logic [CW-1:0] LAST = CW'(SHIFTS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
         cnt_q  <= '0;
      end else if (locked) begin
         if (!scan_en)           locked <= 1'b0;
         else if (cnt_q == LAST) locked <= 1'b0;
         else                    cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R7: a capture edge always opens the lock
   a_r7_capture_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !scan_en) |=> !locked);

   // R8: only reset can close the lock again
   a_r8_lock_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> !locked);

   // R6: the lock survives shifts until the flush window is complete
   a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && scan_en && cnt_q != LAST) |=> locked);
endmodule

// File: rtl/obf_scan_chain.sv
module obf_scan_chain import obf_scan_pkg::*; #(
   parameter int unsigned STAGES          = 3,
   parameter logic [31:0] TAP_MASK        = 32'h1,
   parameter logic [31:0] INV_MASK        = 32'h0,
   parameter decoy_src_e  DECOY_MODE      = DECOY_CONST,
   parameter logic        DECOY_CONST_VAL = 1'b1,
   parameter int unsigned DECOY_SRC       = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en,
   input  logic              scan_in,
   output logic              scan_out,
   input  logic [STAGES-1:0] func_d,
   output logic [STAGES-1:0] func_q
);
   localparam int unsigned    LAT  = STAGES + 1;
   localparam int unsigned    NTAP = STAGES - 2;
   localparam logic [NTAP-1:0] TAPS = TAP_MASK[NTAP-1:0];
   localparam logic           FIX  = out_fix(STAGES, TAP_MASK, INV_MASK);

   // Elaboration-time parameter checks
   generate
      if (STAGES < 3 || STAGES > 32) begin : g_bad_stages
         $error("obf_scan_chain: STAGES must lie in 3..32");
      end
      if ((TAP_MASK >> (STAGES - 2)) != 0) begin : g_bad_taps
         $error("obf_scan_chain: taps allowed only from stages 0..STAGES-3");
      end
      if ((INV_MASK >> (STAGES - 1)) != 0) begin : g_bad_inv
         $error("obf_scan_chain: no inverter allowed in front of the last stage");
      end
      if (DECOY_SRC >= STAGES) begin : g_bad_src
         $error("obf_scan_chain: DECOY_SRC out of range");
      end
   endgenerate

   logic [STAGES-1:0] y;
   logic [STAGES-1:0] shift_d;
   logic              decoy_q;
   logic              net_out;
   logic              locked;

   obf_scan_decoy #(.MODE(DECOY_MODE), .CONST_VAL(DECOY_CONST_VAL)) u_decoy (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_d(scan_in),
      .mirror_d(func_d[DECOY_SRC]), .q(decoy_q)
   );

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign shift_d[i] = decoy_q ^ INV_MASK[i];
         end else if (i < STAGES - 1) begin : g_mid
            assign shift_d[i] = y[i-1] ^ INV_MASK[i];
         end else begin : g_tail
            assign shift_d[i] = y[i-1] ^ (^(y[NTAP-1:0] & TAPS));
         end
         obf_scan_cell u_cell (
            .clk(clk), .rst_n(rst_n), .sel_scan(scan_en),
            .d_func(func_d[i]), .d_scan(shift_d[i]), .q(y[i])
         );
      end
   endgenerate

   // Output correction: removes the tapped terms and the inverter parity
   assign net_out = y[STAGES-1] ^ (^(y[STAGES-2:1] & TAPS)) ^ FIX;

   obf_scan_guard #(.SHIFTS(LAT)) u_guard (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .locked(locked)
   );

   assign scan_out = locked ? 1'b0 : net_out;
   assign func_q   = y;

   // Shadow delay line for the serial-latency property
   localparam int unsigned RW = $clog2(LAT + 1);
   logic [LAT-1:0] shadow_q;
   logic [RW-1:0]  run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         run_q    <= '0;
      end else if (scan_en) begin
         shadow_q <= {shadow_q[LAT-2:0], scan_in};
         if (run_q != RW'(LAT)) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   // R1: after a full run of shifts the output equals the delayed input
   a_r1_serial_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RW'(LAT) && !locked) |-> scan_out == shadow_q[LAT-1]);

   // R2: a capture edge loads the functional inputs
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> func_q == $past(func_d));
endmodule

// File: tb/obf_scan_chain_tb.sv
`timescale 1ns/1ps
module obf_scan_chain_tb_top;
   import obf_scan_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, scan_en, scan_in;
   logic [2:0] d3, q3;
   logic [4:0] d5, q5;
   logic       so3, so5;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   obf_scan_chain dut_i (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
      .scan_out(so3), .func_d(d3), .func_q(q3)
   );

   obf_scan_chain #(
      .STAGES(5), .TAP_MASK(32'h5), .INV_MASK(32'h6),
      .DECOY_MODE(DECOY_MIRROR), .DECOY_CONST_VAL(1'b0), .DECOY_SRC(1)
   ) dut_wide_i (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
      .scan_out(so5), .func_d(d5), .func_q(q5)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; scan_en = 1'b1; scan_in = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic capture(input logic [2:0] a3, input logic [4:0] a5);
      scan_en = 1'b0; d3 = a3; d5 = a5;
      tick();
   endtask

   // R8: reset image and closed lock
   task automatic t_reset_state();
      do_reset();
      check(q3 == 3'b000, "R8 narrow stages cleared", q3, 0);
      check(q5 == 5'b00000, "R8 wide stages cleared", q5, 0);
      check(so3 == 1'b0, "R8 narrow output locked", so3, 0);
      check(so5 == 1'b0, "R6 wide reset image hidden", so5, 0);
   endtask

   // R6: flush window after reset, then R1/R9 take over
   task automatic t_lock_window();
      logic [7:0] b;
      b = 8'($urandom);
      do_reset();
      scan_en = 1'b1;
      for (int n = 0; n < 8; n++) begin
         scan_in = b[n];
         tick();
         if (n + 1 < 4) check(so3 == 1'b0, "R6 narrow locked", so3, 0);
         else           check(so3 == b[n+1-4], "R1 narrow after flush", so3, b[n+1-4]);
         if (n + 1 < 6) check(so5 == 1'b0, "R6 wide locked", so5, 0);
         else           check(so5 == b[n+1-6], "R9 wide after flush", so5, b[n+1-6]);
      end
   endtask

   // R2: functional capture
   task automatic t_capture(input logic [2:0] a3, input logic [4:0] a5);
      capture(a3, a5);
      check(q3 == a3, "R2 narrow capture", q3, a3);
      check(q5 == a5, "R2 wide capture", q5, a5);
   endtask

   // R3/R5: order in which a captured image leaves the register
   task automatic t_scanout_map();
      logic [2:0] a3;
      logic [4:0] a5;
      a3 = 3'($urandom); a5 = 5'($urandom);
      capture(a3, a5);
      check(so3 == (a3[2] ^ a3[1]), "R3 first bit", so3, a3[2] ^ a3[1]);
      scan_en = 1'b1;
      for (int n = 1; n <= 5; n++) begin
         scan_in = 1'($urandom);
         tick();
         if (n == 1) check(so3 == a3[1], "R3 second bit", so3, a3[1]);
         if (n == 2) check(so3 == a3[0], "R3 third bit", so3, a3[0]);
         if (n == 3) check(so3 == 1'b1, "R5 constant decoy", so3, 1);
         if (n == 4) check(so5 == a5[0], "R9 wide stage 0 bit", so5, a5[0]);
         if (n == 5) check(so5 == a5[1], "R5 mirrored decoy", so5, a5[1]);
      end
   endtask

   // R4: scrambled next state after one shift
   task automatic t_network();
      logic [2:0] a3, e3;
      a3 = 3'($urandom);
      capture(a3, 5'd0);
      scan_en = 1'b1; scan_in = 1'($urandom);
      tick();
      e3 = {a3[1] ^ a3[0], a3[0], 1'b1};
      check(q3 == e3, "R4 shifted image", q3, e3);
   endtask

   // R7: capture opens the lock at once
   task automatic t_lock_capture();
      do_reset();
      capture(3'b010, 5'b00000);
      check(so3 == 1'b1, "R7 narrow image visible", so3, 1);
      check(so5 == 1'b1, "R7 wide image visible", so5, 1);
   endtask

   // R1/R9: long serial streams from a random state
   task automatic t_serial(input int kind);
      logic [39:0] b;
      case (kind)
         0: b = {$urandom, $urandom};
         1: b = '1;
         2: b = 40'hAA_AAAA_AAAA;
         default: b = '0;
      endcase
      capture(3'($urandom), 5'($urandom));
      scan_en = 1'b1;
      for (int n = 0; n < 40; n++) begin
         scan_in = b[n];
         tick();
         if (n + 1 >= 4) check(so3 == b[n+1-4], "R1 narrow delay", so3, b[n+1-4]);
         if (n + 1 >= 6) check(so5 == b[n+1-6], "R9 wide delay", so5, b[n+1-6]);
      end
   endtask

   // R8: reset re-arms the lock after activity
   task automatic t_rearm();
      do_reset();
      scan_en = 1'b1;
      for (int n = 0; n < 3; n++) begin
         scan_in = 1'b1;
         tick();
         check(so3 == 1'b0, "R8 narrow re-locked", so3, 0);
         check(so5 == 1'b0, "R8 wide re-locked", so5, 0);
      end
   endtask

   initial begin
      rst_n = 1'b0; scan_en = 1'b1; scan_in = 1'b0; d3 = '0; d5 = '0;
      t_reset_state();
      t_lock_window();
      t_capture(3'b101, 5'b10110);
      t_capture(3'($urandom), 5'($urandom));
      t_scanout_map();
      t_scanout_map();
      t_network();
      t_network();
      t_lock_capture();
      for (int k = 0; k < 4; k++) t_serial(k);
      t_rearm();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule